// File: doc/BRIEF.md
# SPI Register-File Slave

This block lets an SPI master read and write a bank of byte-wide registers held elsewhere in the chip. Each transaction opens with a command byte, then carries any number of data bytes. The command byte holds a direction bit followed by a seven-bit register address. The block turns the serial traffic into single-cycle read and write strobes on a parallel register port. The register storage sits on the far side of that port and is not part of this block.

Both clock-idle conventions are accepted without any setting. In one convention the clock idles low with sampling on the first edge; in the other it idles high with sampling on the second edge. In both, incoming bits are captured on rising clock edges and outgoing bits change after falling clock edges. The serial pins are oversampled by the chip clock through a synchronizer, so all state lives in one clock domain.

Data bytes after the command byte step through consecutive addresses and wrap at the end of the register space. The serial output stays undriven until a complete read byte is ready. Raising the select line at any point ends the transaction. A partly received byte is then thrown away and the output is released.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, spi_miso_oe, reg_wr_en and reg_rd_en are all 0.
- R2: The first byte of a transaction is taken MSB first. Its bit 7 is the direction (1 = write, 0 = read). Its bits 6..0 are the address, of which the low five bits select one of 32 registers and bits 6..5 are ignored.
- R3: In a write transaction, each complete data byte produces exactly one one-cycle reg_wr_en pulse carrying the byte on reg_wr_data and its register on reg_addr.
- R4: Successive data bytes of one transaction use consecutive registers, and register 31 is followed by register 0, for both writes and reads.
- R5: In a read transaction spi_miso_oe stays 0 throughout the command byte. The first data byte's MSB is driven after the falling clock edge that follows the eighth rising edge, and spi_miso changes only after falling clock edges.
- R6: MOSI is sampled on rising clock edges, and transactions work the same with the clock idling low and with the clock idling high.
- R7: While spi_cs_n is high, clock and data activity causes no register strobe and leaves spi_miso_oe at 0.
- R8: Raising spi_cs_n in the middle of a byte discards that byte with no write, drops spi_miso_oe, and the next transaction starts again with a command byte.
- R9: A read transaction issues one reg_rd_en pulse at the end of the command byte and one at the end of every further completed byte. reg_rd_data must be valid the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad; 0 means high impedance |
| reg_addr | output | 5 | Register index for the current strobe |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data, valid one cycle after reg_rd_en |

## Verification
Every serial pin passes through two synchronizer stages and one edge register, so a strobe appears about four chip cycles after the rising serial edge that completes its byte. A driven output bit appears about four cycles after a falling serial edge. The bench holds each serial clock level for eight chip cycles. It reads spi_miso and spi_miso_oe just before it raises the serial clock, and it checks register contents only after the select line has gone high and several cycles have passed. Each sample therefore lands well after the design's response is due and before the next edge can change it.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2
   } spi_phase_e;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
   parameter int          STAGES    = 2,
   parameter int          WIDTH     = 3,
   parameter logic [31:0] RESET_VAL = 32'd0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   initial begin
      if (STAGES < 2) $error("spi_rf_sync: STAGES must be at least 2");
      if (WIDTH < 1 || WIDTH > 32) $error("spi_rf_sync: WIDTH out of range");
   end

   localparam logic [WIDTH-1:0] RST_V = RESET_VAL[WIDTH-1:0];

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_V;
               else        stage_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_V;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
   import spi_rf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CMD_ADDR_W = 7,
   parameter int ADDR_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sck_rise,
   input  logic              mosi_bit,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   output logic              in_read,
   output logic              at_boundary
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   initial begin
      if ((1 << CNT_W) != DATA_W) $error("spi_rf_frame: DATA_W must be a power of two");
      if (CMD_ADDR_W + 1 != DATA_W) $error("spi_rf_frame: command must be one byte");
      if (ADDR_W > CMD_ADDR_W) $error("spi_rf_frame: ADDR_W too wide");
   end

   spi_phase_e        phase_q;
   logic [CNT_W-1:0]  bitcnt_q;
   logic [DATA_W-1:0] shreg_q;
   logic [DATA_W-1:0] shift_nxt;
   logic [ADDR_W-1:0] ptr_q;
   logic              cmd_dir;
   logic [ADDR_W-1:0] cmd_addr;

   assign shift_nxt = {shreg_q[DATA_W-2:0], mosi_bit};
   assign cmd_dir   = shift_nxt[DATA_W-1];
   assign cmd_addr  = shift_nxt[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_CMD;
         bitcnt_q    <= '0;
         shreg_q     <= '0;
         ptr_q       <= '0;
         reg_addr    <= '0;
         reg_wr_en   <= 1'b0;
         reg_wr_data <= '0;
         reg_rd_en   <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         if (!cs_active) begin
            phase_q  <= PH_CMD;
            bitcnt_q <= '0;
         end else if (sck_rise) begin
            shreg_q  <= shift_nxt;
            bitcnt_q <= bitcnt_q + CNT_W'(1);
            if (bitcnt_q == LAST_BIT) begin
               unique case (phase_q)
                  PH_CMD: begin
                     if (cmd_dir) begin
                        phase_q <= PH_WRITE;
                        ptr_q   <= cmd_addr;
                     end else begin
                        phase_q   <= PH_READ;
                        reg_rd_en <= 1'b1;
                        reg_addr  <= cmd_addr;
                        ptr_q     <= cmd_addr + ADDR_W'(1);
                     end
                  end
                  PH_WRITE: begin
                     reg_wr_en   <= 1'b1;
                     reg_wr_data <= shift_nxt;
                     reg_addr    <= ptr_q;
                     ptr_q       <= ptr_q + ADDR_W'(1);
                  end
                  PH_READ: begin
                     reg_rd_en <= 1'b1;
                     reg_addr  <= ptr_q;
                     ptr_q     <= ptr_q + ADDR_W'(1);
                  end
                  default: phase_q <= PH_CMD;
               endcase
            end
         end
      end
   end

   assign in_read     = (phase_q == PH_READ);
   assign at_boundary = (bitcnt_q == '0);

endmodule

// File: rtl/spi_rf_tx.sv
module spi_rf_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sck_fall,
   input  logic              in_read,
   input  logic              at_boundary,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              miso,
   output logic              miso_oe
);

   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic [DATA_W-1:0] txsh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         txsh_q      <= '0;
         miso_oe     <= 1'b0;
      end else if (!cs_active) begin
         hold_full_q <= 1'b0;
         miso_oe     <= 1'b0;
      end else begin
         if (rd_valid) begin
            hold_q      <= rd_data;
            hold_full_q <= 1'b1;
         end
         if (sck_fall && in_read) begin
            if (at_boundary && hold_full_q) begin
               txsh_q      <= hold_q;
               hold_full_q <= 1'b0;
               miso_oe     <= 1'b1;
            end else begin
               txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = txsh_q[DATA_W-1];

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
   parameter int REG_COUNT   = 32,
   parameter int DATA_W      = 8,
   parameter int CMD_ADDR_W  = 7,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rd_data
);

   initial begin
      if ((1 << ADDR_W) != REG_COUNT) $error("spi_regfile_slave: REG_COUNT must be a power of two");
      if (REG_COUNT > (1 << CMD_ADDR_W)) $error("spi_regfile_slave: REG_COUNT exceeds command address range");
   end

   localparam int PIN_W = 3;
   localparam logic [31:0] PIN_RST = 32'b100;

   logic [PIN_W-1:0] pins_s;
   logic             sck_s, mosi_s, cs_n_s;
   logic             sck_d;
   logic             cs_active, sck_rise, sck_fall;
   logic             in_read, at_boundary, rd_valid_q;

   spi_rf_sync #(
      .STAGES   (SYNC_STAGES),
      .WIDTH    (PIN_W),
      .RESET_VAL(PIN_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_mosi, spi_sck}),
      .dout (pins_s)
   );

   assign sck_s  = pins_s[0];
   assign mosi_s = pins_s[1];
   assign cs_n_s = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d      <= 1'b0;
         rd_valid_q <= 1'b0;
      end else begin
         sck_d      <= sck_s;
         rd_valid_q <= reg_rd_en;
      end
   end

   assign cs_active = ~cs_n_s;
   assign sck_rise  = cs_active &  sck_s & ~sck_d;
   assign sck_fall  = cs_active & ~sck_s &  sck_d;

   spi_rf_frame #(
      .DATA_W    (DATA_W),
      .CMD_ADDR_W(CMD_ADDR_W),
      .ADDR_W    (ADDR_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_active  (cs_active),
      .sck_rise   (sck_rise),
      .mosi_bit   (mosi_s),
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wr_data(reg_wr_data),
      .reg_rd_en  (reg_rd_en),
      .in_read    (in_read),
      .at_boundary(at_boundary)
   );

   spi_rf_tx #(
      .DATA_W(DATA_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_active  (cs_active),
      .sck_fall   (sck_fall),
      .in_read    (in_read),
      .at_boundary(at_boundary),
      .rd_valid   (rd_valid_q),
      .rd_data    (reg_rd_data),
      .miso       (spi_miso),
      .miso_oe    (spi_miso_oe)
   );

endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_active,
   input logic sck_fall,
   input logic reg_wr_en,
   input logic reg_rd_en,
   input logic spi_miso,
   input logic spi_miso_oe
);

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_rd_en)); // R9

   AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en); // R3

   AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en); // R9

   AST_WR_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $past(cs_active)); // R7

   AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> !spi_miso_oe); // R8

   AST_MISO_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_miso_oe && $past(spi_miso_oe) && !$past(sck_fall)) |-> $stable(spi_miso)); // R5

endmodule

bind spi_regfile_slave spi_regfile_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_active  (cs_active),
   .sck_fall   (sck_fall),
   .reg_wr_en  (reg_wr_en),
   .reg_rd_en  (reg_rd_en),
   .spi_miso   (spi_miso),
   .spi_miso_oe(spi_miso_oe)
);

// File: tb/spi_regfile_slave_bench.sv
`timescale 1ns/1ps
module spi_regfile_slave_bench;

   localparam int HP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe;
   logic [4:0] reg_addr;
   logic       reg_wr_en, reg_rd_en;
   logic [7:0] reg_wr_data;
   logic [7:0] reg_rd_data;

   int checks = 0;
   int errors = 0;
   int wr_count = 0;
   int rd_count = 0;
   bit finished = 0;

   logic [7:0] mem [32];
   logic [7:0] exp_mem [32];
   logic [7:0] tx_q [16];
   logic [7:0] rx_q [16];
   bit cmd_oe_seen;
   bit last_oe;

   always #2.5 clk = ~clk;

   spi_regfile_slave u_spi_regfile_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sck    (sck),
      .spi_cs_n   (cs_n),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .spi_miso_oe(miso_oe),
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wr_data(reg_wr_data),
      .reg_rd_en  (reg_rd_en),
      .reg_rd_data(reg_rd_data)
   );

   // register storage on the far side of the parallel port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mem[i] <= 8'h40 + 8'(i);
         reg_rd_data <= '0;
         wr_count    <= 0;
         rd_count    <= 0;
      end else begin
         if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            wr_count      <= wr_count + 1;
         end
         if (reg_rd_en) begin
            reg_rd_data <= mem[reg_addr];
            rd_count    <= rd_count + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_frame(input bit m3, input int nbits);
      sck = m3; cs_n = 1'b1; wait_clk(HP);
      cs_n = 1'b0; wait_clk(HP);
      cmd_oe_seen = 0;
      for (int k = 0; k < nbits; k++) begin
         sck  = 1'b0;
         mosi = tx_q[k/8][7-(k%8)];
         wait_clk(HP);
         if (k < 8 && miso_oe) cmd_oe_seen = 1;
         rx_q[k/8][7-(k%8)] = miso;
         sck = 1'b1;
         wait_clk(HP);
      end
      if (!m3) begin
         sck = 1'b0;
         wait_clk(HP);
      end
      last_oe = miso_oe;
      cs_n = 1'b1;
      wait_clk(4*HP);
   endtask

   task automatic t_reset;
      wait_clk(3);
      check(miso_oe == 1'b0, "R1 oe", int'(miso_oe), 0);
      check(reg_wr_en == 1'b0, "R1 wr_en", int'(reg_wr_en), 0);
      check(reg_rd_en == 1'b0, "R1 rd_en", int'(reg_rd_en), 0);
   endtask

   task automatic t_write_burst_mode0;
      int w0;
      w0 = wr_count;
      tx_q[0] = 8'h83; tx_q[1] = 8'hA1; tx_q[2] = 8'hA2; tx_q[3] = 8'hA3;
      spi_frame(1'b0, 32);
      exp_mem[3] = 8'hA1; exp_mem[4] = 8'hA2; exp_mem[5] = 8'hA3;
      for (int i = 3; i < 6; i++)
         check(mem[i] == exp_mem[i], "R3/R6 write burst idle-low", int'(mem[i]), int'(exp_mem[i]));
      check(wr_count - w0 == 3, "R3 one strobe per byte", wr_count - w0, 3);
   endtask

   task automatic t_cmd_high_bits;
      tx_q[0] = 8'hE5; tx_q[1] = 8'h5A;
      spi_frame(1'b1, 16);
      exp_mem[5] = 8'h5A;
      check(mem[5] == 8'h5A, "R2 address bits 6..5 ignored", int'(mem[5]), 8'h5A);
      check(mem[4] == exp_mem[4], "R2 neighbour untouched", int'(mem[4]), int'(exp_mem[4]));
   endtask

   task automatic t_read_wrap_mode3;
      int r0;
      r0 = rd_count;
      tx_q[0] = 8'h1E; tx_q[1] = 8'h00; tx_q[2] = 8'h00; tx_q[3] = 8'h00;
      spi_frame(1'b1, 32);
      check(cmd_oe_seen == 0, "R5 no drive during command", int'(cmd_oe_seen), 0);
      check(rx_q[1] == exp_mem[30], "R5/R6 read byte reg30", int'(rx_q[1]), int'(exp_mem[30]));
      check(rx_q[2] == exp_mem[31], "R4 read reg31", int'(rx_q[2]), int'(exp_mem[31]));
      check(rx_q[3] == exp_mem[0], "R4 read wraps to reg0", int'(rx_q[3]), int'(exp_mem[0]));
      check(rd_count - r0 == 4, "R9 read strobes", rd_count - r0, 4);
      check(miso_oe == 1'b0, "R8 oe released after frame", int'(miso_oe), 0);
   endtask

   task automatic t_read_mode0;
      tx_q[0] = 8'h03; tx_q[1] = 8'h00; tx_q[2] = 8'h00;
      spi_frame(1'b0, 24);
      check(cmd_oe_seen == 0, "R5 no drive during command idle-low", int'(cmd_oe_seen), 0);
      check(rx_q[1] == exp_mem[3], "R6 read idle-low reg3", int'(rx_q[1]), int'(exp_mem[3]));
      check(rx_q[2] == exp_mem[4], "R4 read idle-low reg4", int'(rx_q[2]), int'(exp_mem[4]));
   endtask

   task automatic t_write_wrap_mode3;
      tx_q[0] = 8'h9F; tx_q[1] = 8'hC1; tx_q[2] = 8'hC2;
      spi_frame(1'b1, 24);
      exp_mem[31] = 8'hC1; exp_mem[0] = 8'hC2;
      check(mem[31] == 8'hC1, "R4 write reg31", int'(mem[31]), 8'hC1);
      check(mem[0] == 8'hC2, "R4 write wraps to reg0", int'(mem[0]), 8'hC2);
      check(mem[1] == exp_mem[1], "R4 reg1 untouched", int'(mem[1]), int'(exp_mem[1]));
   endtask

   task automatic t_ignore_deselected;
      int w0, r0;
      bit oe_seen;
      w0 = wr_count; r0 = rd_count; oe_seen = 0;
      cs_n = 1'b1; mosi = 1'b1;
      for (int k = 0; k < 24; k++) begin
         sck = 1'b0; wait_clk(HP);
         sck = 1'b1; wait_clk(HP);
         if (miso_oe) oe_seen = 1;
      end
      sck = 1'b0; wait_clk(4*HP);
      check(wr_count == w0, "R7 no write while deselected", wr_count - w0, 0);
      check(rd_count == r0, "R7 no read while deselected", rd_count - r0, 0);
      check(oe_seen == 0, "R7 oe stays low", int'(oe_seen), 0);
   endtask

   task automatic t_abort;
      int w0;
      w0 = wr_count;
      tx_q[0] = 8'h8A; tx_q[1] = 8'hFF;
      spi_frame(1'b0, 12);
      check(wr_count == w0, "R8 partial byte not written", wr_count - w0, 0);
      check(mem[10] == exp_mem[10], "R8 reg10 unchanged", int'(mem[10]), int'(exp_mem[10]));
      tx_q[0] = 8'h8A; tx_q[1] = 8'h77;
      spi_frame(1'b0, 16);
      exp_mem[10] = 8'h77;
      check(mem[10] == 8'h77, "R8 next frame restarts at command", int'(mem[10]), 8'h77);
      tx_q[0] = 8'h0A; tx_q[1] = 8'h00;
      spi_frame(1'b0, 12);
      check(last_oe == 1'b1, "R5 driving mid read byte", int'(last_oe), 1);
      check(miso_oe == 1'b0, "R8 oe dropped after abort", int'(miso_oe), 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) exp_mem[i] = 8'h40 + 8'(i);
      for (int i = 0; i < 16; i++) begin tx_q[i] = '0; rx_q[i] = '0; end
      wait_clk(4);
      rst_n = 1'b1;
      t_reset();
      t_write_burst_mode0();
      t_cmd_high_bits();
      t_read_wrap_mode3();
      t_read_mode0();
      t_write_wrap_mode3();
      t_ignore_deselected();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule